// File: doc/BRIEF.md
# Interrupt Acknowledge Daisy-Chain Responder

This block is a byte-wide interrupter for a backplane whose seven active-low interrupt request lines rank one to seven. A one-cycle request pulse from the local side asks for service. The block latches a 3-bit priority level and pulls the matching request line low. It then follows the interrupt acknowledge handshake coming from the backplane. The acknowledge-in, address strobe and lower data strobe inputs each pass through a two-flop synchroniser, and edges are found by comparing successive synchronised samples.

When an acknowledge cycle reaches the block, it decides whether it is the interrupter being served. If it is, it places the 8-bit status/ID byte on the low data byte, enables the data drivers and asserts the data acknowledge. It releases both the acknowledge and its request line once the data strobe returns high. If it is not, it hands the cycle on down the chain. Its acknowledge-out then follows the raw, unsynchronised address strobe, so the chain adds no synchroniser delay.

The block also passes the chain on when it has nothing pending. The level and status/ID values are plain inputs driven from elsewhere.

Top module: `vme_irq_responder`

## Requirements
- R1: After a request pulse with level L in 1..7 is accepted, exactly the line irq_n_o[L] is driven low and all other request lines stay high.
- R2: A request pulse with level 0 drives no request line, and the block stays idle.
- R3: A request pulse that arrives while a request is pending is ignored: the pending line does not change.
- R4: The block responds only when a request is pending, a falling edge of iackin_n_i has been seen, addr_i (A3..A1) equals the pending level, write_n_i is high (read) and ds0_n_i is low. A response drives data_o with the status/ID byte, sets data_oe_o and drives dtack_n_o low.
- R5: Once ds0_n_i returns high during a response, dtack_n_o goes high, data_oe_o goes low and the request line is released.
- R6: On an acknowledge cycle with a different address or with write_n_i low, the block asserts neither dtack_n_o nor data_oe_o, drives iackout_n_o low, and keeps its request pending for a later cycle.
- R7: With nothing pending, a falling edge of iackin_n_i makes the block pass the cycle on through iackout_n_o.
- R8: While passing a cycle on, iackout_n_o equals as_n_i combinationally, with no clock edge between them. At all other times iackout_n_o is high. Pass-on ends at the synchronised rising edge of the address strobe.
- R9: While rst_n is low at a clock edge, every request line, dtack_n_o and iackout_n_o are high and data_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | One-cycle interrupt request pulse |
| level_i | input | 3 | Priority level of the request, 0 means none |
| vector_i | input | 8 | Status/ID byte returned on a response |
| iackin_n_i | input | 1 | Daisy-chain acknowledge in, active low, asynchronous |
| as_n_i | input | 1 | Address strobe, active low, asynchronous |
| ds0_n_i | input | 1 | Lower data strobe, active low, asynchronous |
| addr_i | input | 3 | Address lines A3..A1 carrying the level being acknowledged |
| write_n_i | input | 1 | Write line, low for a write cycle |
| irq_n_o | output | 7 | Request lines, bit k is level k, active low |
| data_o | output | 8 | Low data byte D7..D0 |
| data_oe_o | output | 1 | Data driver enable |
| dtack_n_o | output | 1 | Data acknowledge, active low |
| iackout_n_o | output | 1 | Daisy-chain acknowledge out, active low |

## Verification
The hardest situation to reach from the ports is the pass-on state, where iackout_n_o must follow the raw strobe with no clock in between. The bench enters that state with a mismatching or write cycle, then raises as_n_i between clock edges. It samples iackout_n_o before the next edge, which proves the path is combinational. A second hard case is a non-matching cycle followed by a matching one. Here the bench must show that the request survived the first cycle and that a new acknowledge-in falling edge is needed to re-arm the response.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;

    localparam int LEVEL_W   = 3;
    localparam int NUM_LINES = (1 << LEVEL_W) - 1;
    localparam int VEC_W     = 8;

    // Index of each synchronised strobe inside the synchroniser vector
    localparam int SIG_IACK  = 0;
    localparam int SIG_AS    = 1;
    localparam int SIG_DS0   = 2;
    localparam int NUM_SYNC  = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IRQ,
        ST_WAIT_AS,
        ST_WAIT_DS,
        ST_CHECK,
        ST_DATA_OUT,
        ST_DTACK,
        ST_PASS_PEND,
        ST_PASS_IDLE
    } resp_state_e;

    typedef struct packed {
        resp_state_e            state;
        logic [LEVEL_W-1:0]     level;
        logic [NUM_LINES-1:0]   irq_n;
        logic [VEC_W-1:0]       data;
        logic                   oe;
        logic                   dtack_n;
    } resp_regs_t;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] edge_o
);

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] prev_d;

    always_comb begin
        chain_d[0] = async_i;
        prev_d     = chain_q[STAGES-1];
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
            prev_q <= '1;
        end else begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
            prev_q <= prev_d;
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign edge_o  = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/level_line_decode.sv
module level_line_decode
    import irq_resp_pkg::*;
(
    input  logic [LEVEL_W-1:0]   level_i,
    output logic [NUM_LINES-1:0] lines_n_o
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign lines_n_o[i] = (level_i != LEVEL_W'(i + 1));
    end

endmodule

// File: rtl/iack_fsm.sv
module iack_fsm
    import irq_resp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [LEVEL_W-1:0]   level_i,
    input  logic [NUM_LINES-1:0] lines_n_i,
    input  logic [VEC_W-1:0]     vector_i,
    input  logic [NUM_SYNC-1:0]  sync_lvl_i,
    input  logic [NUM_SYNC-1:0]  sync_edge_i,
    input  logic [LEVEL_W-1:0]   addr_i,
    input  logic                 write_n_i,
    output logic [NUM_LINES-1:0] irq_n_o,
    output logic [VEC_W-1:0]     data_o,
    output logic                 data_oe_o,
    output logic                 dtack_n_o,
    output logic                 pass_o
);

    resp_regs_t r_q, r_d;

    logic iack_fall, as_low, as_rise, ds0_low, ds0_rise;

    always_comb begin
        iack_fall = sync_edge_i[SIG_IACK] & ~sync_lvl_i[SIG_IACK];
        as_low    = ~sync_lvl_i[SIG_AS];
        as_rise   = sync_edge_i[SIG_AS] & sync_lvl_i[SIG_AS];
        ds0_low   = ~sync_lvl_i[SIG_DS0];
        ds0_rise  = sync_edge_i[SIG_DS0] & sync_lvl_i[SIG_DS0];
    end

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                r_d.irq_n = '1;
                if (req_i && (level_i != '0)) begin
                    r_d.state = ST_IRQ;
                    r_d.level = level_i;
                    r_d.irq_n = lines_n_i;
                end else if (iack_fall) begin
                    r_d.state = ST_PASS_IDLE;
                end
            end
            ST_IRQ: begin
                if (iack_fall) r_d.state = ST_WAIT_AS;
            end
            ST_WAIT_AS: begin
                if (as_low) r_d.state = ST_WAIT_DS;
            end
            ST_WAIT_DS: begin
                if (ds0_low) r_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                if ((addr_i == r_q.level) && write_n_i) begin
                    r_d.state = ST_DATA_OUT;
                    r_d.data  = vector_i;
                    r_d.oe    = 1'b1;
                end else begin
                    r_d.state = ST_PASS_PEND;
                end
            end
            ST_DATA_OUT: begin
                r_d.state   = ST_DTACK;
                r_d.dtack_n = 1'b0;
            end
            ST_DTACK: begin
                if (ds0_rise || !ds0_low) begin
                    r_d.state   = ST_IDLE;
                    r_d.dtack_n = 1'b1;
                    r_d.oe      = 1'b0;
                    r_d.data    = '0;
                    r_d.irq_n   = '1;
                end
            end
            ST_PASS_PEND: begin
                if (as_rise) r_d.state = ST_IRQ;
            end
            ST_PASS_IDLE: begin
                if (as_rise) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.level   <= '0;
            r_q.irq_n   <= '1;
            r_q.data    <= '0;
            r_q.oe      <= 1'b0;
            r_q.dtack_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_n_o   = r_q.irq_n;
    assign data_o    = r_q.data;
    assign data_oe_o = r_q.oe;
    assign dtack_n_o = r_q.dtack_n;
    assign pass_o    = (r_q.state == ST_PASS_PEND) || (r_q.state == ST_PASS_IDLE);

    // R5
    release_after_ds0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DTACK && ds0_rise) |=> (dtack_n_o && !data_oe_o && (&irq_n_o)));

    // R3
    pending_line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state inside {ST_IRQ, ST_WAIT_AS, ST_WAIT_DS, ST_CHECK, ST_DATA_OUT, ST_PASS_PEND})
        |=> $stable(irq_n_o));

    // R4
    dtack_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n_o |-> (data_oe_o && !(&irq_n_o)));

    // R6
    no_drive_while_passing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (dtack_n_o && !data_oe_o));

endmodule

// File: rtl/vme_irq_responder.sv
module vme_irq_responder
    import irq_resp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [LEVEL_W-1:0]   level_i,
    input  logic [VEC_W-1:0]     vector_i,
    input  logic                 iackin_n_i,
    input  logic                 as_n_i,
    input  logic                 ds0_n_i,
    input  logic [LEVEL_W-1:0]   addr_i,
    input  logic                 write_n_i,
    output logic [NUM_LINES:1]   irq_n_o,
    output logic [VEC_W-1:0]     data_o,
    output logic                 data_oe_o,
    output logic                 dtack_n_o,
    output logic                 iackout_n_o
);

    logic [NUM_SYNC-1:0]  raw_strobes;
    logic [NUM_SYNC-1:0]  sync_lvl;
    logic [NUM_SYNC-1:0]  sync_edge;
    logic [NUM_LINES-1:0] decoded_n;
    logic [NUM_LINES-1:0] lines_n;
    logic                 passing;

    always_comb begin
        raw_strobes           = '1;
        raw_strobes[SIG_IACK] = iackin_n_i;
        raw_strobes[SIG_AS]   = as_n_i;
        raw_strobes[SIG_DS0]  = ds0_n_i;
    end

    strobe_sync #(
        .WIDTH  (NUM_SYNC),
        .STAGES (2)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_strobes),
        .level_o (sync_lvl),
        .edge_o  (sync_edge)
    );

    level_line_decode i_decode (
        .level_i   (level_i),
        .lines_n_o (decoded_n)
    );

    iack_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .level_i     (level_i),
        .lines_n_i   (decoded_n),
        .vector_i    (vector_i),
        .sync_lvl_i  (sync_lvl),
        .sync_edge_i (sync_edge),
        .addr_i      (addr_i),
        .write_n_i   (write_n_i),
        .irq_n_o     (lines_n),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o),
        .dtack_n_o   (dtack_n_o),
        .pass_o      (passing)
    );

    assign irq_n_o     = lines_n;
    // Raw strobe forwarded without synchronisation to bound chain delay
    assign iackout_n_o = passing ? as_n_i : 1'b1;

    // R1
    single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~irq_n_o));

    // R8
    iackout_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iackout_n_o |-> (dtack_n_o && !data_oe_o));

endmodule

// File: tb/test_vme_irq_responder.sv
module test_vme_irq_responder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic [2:0] level_i = '0;
    logic [7:0] vector_i = '0;
    logic       iackin_n_i = 1'b1;
    logic       as_n_i = 1'b1;
    logic       ds0_n_i = 1'b1;
    logic [2:0] addr_i = '0;
    logic       write_n_i = 1'b1;
    logic [7:1] irq_n_o;
    logic [7:0] data_o;
    logic       data_oe_o;
    logic       dtack_n_o;
    logic       iackout_n_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    vme_irq_responder i_vme_irq_responder (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .level_i     (level_i),
        .vector_i    (vector_i),
        .iackin_n_i  (iackin_n_i),
        .as_n_i      (as_n_i),
        .ds0_n_i     (ds0_n_i),
        .addr_i      (addr_i),
        .write_n_i   (write_n_i),
        .irq_n_o     (irq_n_o),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o),
        .dtack_n_o   (dtack_n_o),
        .iackout_n_o (iackout_n_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:1] line_for(input logic [2:0] lvl);
        logic [7:1] v = '1;
        if (lvl != 0) v[lvl] = 1'b0;
        return v;
    endfunction

    task automatic pulse_req(input logic [2:0] lvl);
        level_i = lvl;
        req_i   = 1'b1;
        cycles(1);
        req_i   = 1'b0;
        cycles(1);
    endtask

    task automatic start_iack(input logic [2:0] a, input logic wr_n);
        addr_i     = a;
        write_n_i  = wr_n;
        iackin_n_i = 1'b0;
        cycles(1);
        as_n_i     = 1'b0;
        cycles(1);
        ds0_n_i    = 1'b0;
        cycles(10);
    endtask

    task automatic end_iack();
        ds0_n_i    = 1'b1;
        as_n_i     = 1'b1;
        iackin_n_i = 1'b1;
        cycles(8);
    endtask

    task automatic t_reset();
        check("R9 irq lines", irq_n_o, 7'h7f);
        check("R9 dtack", dtack_n_o, 1);
        check("R9 oe", data_oe_o, 0);
        check("R9 iackout", iackout_n_o, 1);
    endtask

    task automatic t_respond(input logic [2:0] lvl, input logic [7:0] vec);
        vector_i = vec;
        pulse_req(lvl);
        check("R1 line select", irq_n_o, line_for(lvl));
        start_iack(lvl, 1'b1);
        check("R4 dtack", dtack_n_o, 0);
        check("R4 oe", data_oe_o, 1);
        check("R4 vector", data_o, vec);
        check("R4 iackout held", iackout_n_o, 1);
        end_iack();
        check("R5 dtack released", dtack_n_o, 1);
        check("R5 oe released", data_oe_o, 0);
        check("R5 line released", irq_n_o, 7'h7f);
    endtask

    task automatic t_level_zero();
        pulse_req(3'd0);
        check("R2 no line", irq_n_o, 7'h7f);
        start_iack(3'd0, 1'b1);
        check("R2 no dtack", dtack_n_o, 1);
        check("R7 idle pass", iackout_n_o, 0);
        end_iack();
        check("R7 pass ended", iackout_n_o, 1);
    endtask

    task automatic t_busy_ignored();
        pulse_req(3'd3);
        pulse_req(3'd6);
        check("R3 second request ignored", irq_n_o, line_for(3'd3));
        vector_i = 8'h3c;
        start_iack(3'd3, 1'b1);
        check("R3 original level answered", data_o, 8'h3c);
        end_iack();
        check("R3 line released", irq_n_o, 7'h7f);
    endtask

    task automatic t_pass_on(input logic [2:0] lvl, input logic [2:0] a, input logic wr_n);
        vector_i = 8'h5a;
        pulse_req(lvl);
        start_iack(a, wr_n);
        check("R6 no dtack", dtack_n_o, 1);
        check("R6 no oe", data_oe_o, 0);
        check("R6 iackout low", iackout_n_o, 0);
        check("R6 still pending", irq_n_o, line_for(lvl));
        #1 as_n_i = 1'b1;
        #1 check("R8 raw strobe follow", iackout_n_o, 1);
        as_n_i = 1'b0;
        #1 check("R8 raw strobe low", iackout_n_o, 0);
        end_iack();
        check("R8 iackout after exit", iackout_n_o, 1);
        check("R6 pending after pass", irq_n_o, line_for(lvl));
        start_iack(lvl, 1'b1);
        check("R6 later cycle answered", dtack_n_o, 0);
        check("R6 later vector", data_o, 8'h5a);
        end_iack();
        check("R6 released", irq_n_o, 7'h7f);
    endtask

    initial begin
        cycles(4);
        t_reset();
        rst_n = 1'b1;
        cycles(2);
        for (int l = 1; l < 8; l++) t_respond(3'(l), 8'(8'h10 + l * 8'h11));
        t_level_zero();
        t_busy_ignored();
        t_pass_on(3'd2, 3'd5, 1'b1);
        t_pass_on(3'd4, 3'd4, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule